// File: doc/BRIEF.md
# Paged Development RAM Access Window

This block gives an external host a narrow, paged way into an 8 KB development RAM, and it places that same RAM in the processor address map. The host sends byte-wide requests, each carrying a host page address, a byte offset and write data. One host page holds a page-select register. Another host page is a 256-byte window onto whichever RAM page is currently selected. A third host page holds a one-bit remap control. Reads return one byte on a response channel. Writes return nothing.

On the processor side, the block decodes each address into a select for the one-time-programmable (OTP) memory or a select for the development RAM, together with the RAM byte address. The remap bit places the RAM either over the OTP range or in a separate range of its own. An external trace-enable input cancels the overlay. Software download through the window is allowed only while the remap bit is clear.

Host requests use a valid/ready handshake. A request is accepted in a cycle where `host_req_valid` and `host_req_ready` are both high. Every read produces exactly one response. The response is held, unchanged, until `host_rsp_ready` is seen high with `host_rsp_valid`. While a response is waiting, `host_req_ready` stays low, so no new request of either kind is accepted.

Top module: `devram_window`

## Requirements
- R1: After reset the remap bit and the page-select register are 0, no response is pending, `host_req_ready` is 1, and neither RAM strobe is active.
- R2: A write to host page 0x02 loads the full 8-bit page-select register. A read of host page 0x02 at any offset returns its value.
- R3: An accepted write to host page 0x03 raises `ram_we` in the acceptance cycle only. In that cycle `ram_addr` is {page_select[4:0], offset[7:0]} and `ram_wdata` is the write byte.
- R4: An accepted read to host page 0x03 raises `ram_re` in the acceptance cycle. The next cycle shows `host_rsp_valid` with the addressed RAM byte on `host_rsp_data`.
- R5: While the page-select value is above 31, window accesses raise no RAM strobe, and window reads return 0x00.
- R6: Host page 0x00, offset 0x00 holds the remap bit: write data bit 0 loads it, and a read returns it in bit 0 with all other bits 0. Other offsets of page 0x00 are ignored on write and read as 0x00.
- R7: While the remap bit is 1, window accesses raise no RAM strobe, and window reads return 0x00.
- R8: Overlay is active when remap is 1 and `trace_en` is 0. A processor access in the OTP range (upper three address bits equal to those of OTP_BASE, 0x0000) asserts `cpu_sel_otp` when overlay is inactive. It asserts `cpu_sel_ram` instead when overlay is active. The two selects are never high together.
- R9: A processor access in the separate range (upper three bits equal to those of SEP_BASE, 0x4000) asserts `cpu_sel_ram` only when overlay is inactive. `cpu_ram_addr` is the lower 13 address bits whenever `cpu_sel_ram` is high.
- R10: While `trace_en` is 1, the RAM is never selected for the OTP range, whatever the remap bit holds.
- R11: While a response is pending, `host_req_ready` is 0, and `host_rsp_valid` and `host_rsp_data` hold steady until `host_rsp_ready` is seen.
- R12: Writes to host pages other than 0x00, 0x02 and 0x03 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Block can accept a request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_page | input | 8 | Host page address |
| host_req_offset | input | 8 | Byte offset within the host page |
| host_req_wdata | input | 8 | Write byte |
| host_rsp_valid | output | 1 | Read response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_data | output | 8 | Read response byte |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 13 | RAM byte address for host access |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid the cycle after `ram_re` |
| trace_en | input | 1 | Trace capture active; cancels overlay |
| cpu_valid | input | 1 | Processor access valid |
| cpu_addr | input | 16 | Processor byte address |
| cpu_sel_otp | output | 1 | Processor access goes to OTP |
| cpu_sel_ram | output | 1 | Processor access goes to development RAM |
| cpu_ram_addr | output | 13 | RAM byte address for processor access |

## Verification
The embedded properties check, on every cycle, the following rules:
- the two processor selects are never high together;
- no RAM strobe fires while remap is set or the page is out of range;
- a RAM read is followed by a response;
- a stalled response keeps its data;
- trace capture never lets the RAM shadow OTP.

Other behaviour needs the bench's scenarios, which compare every output each cycle against a behavioural model. These cover:
- that a byte written on one page reads back through the window at the correct address;
- that register values round-trip;
- that ignored pages leave state untouched;
- that back-pressure stretched over several cycles loses no request.

// File: rtl/devwin_pkg.sv
package devwin_pkg;
  localparam int HOST_DW = 8;

  localparam logic [7:0] HPG_REMAP  = 8'h00;
  localparam logic [7:0] HPG_PAGE   = 8'h02;
  localparam logic [7:0] HPG_WINDOW = 8'h03;

  typedef enum logic [1:0] {
    TGT_REMAP,
    TGT_PAGE,
    TGT_WINDOW,
    TGT_NONE
  } host_tgt_e;

  function automatic host_tgt_e decode_tgt(input logic [7:0] page);
    case (page)
      HPG_REMAP:  return TGT_REMAP;
      HPG_PAGE:   return TGT_PAGE;
      HPG_WINDOW: return TGT_WINDOW;
      default:    return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/devwin_regs.sv
module devwin_regs
  import devwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  host_tgt_e          tgt,
  input  logic [7:0]         offset,
  input  logic [HOST_DW-1:0] wdata,
  output logic               remap_q,
  output logic [7:0]         page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
      page_q  <= '0;
    end else if (wr_fire) begin
      if (tgt == TGT_REMAP && offset == 8'h00) remap_q <= wdata[0];
      if (tgt == TGT_PAGE) page_q <= wdata;
    end
  end
endmodule

// File: rtl/devwin_host_port.sv
module devwin_host_port
  import devwin_pkg::*;
#(
  parameter int RAM_AW    = 13,
  parameter int OFS_W     = 8,
  parameter int PAGE_W    = 5,
  parameter int NUM_PAGES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic [7:0]         host_req_page,
  input  logic [7:0]         host_req_offset,
  input  logic [HOST_DW-1:0] host_req_wdata,
  output logic               host_rsp_valid,
  input  logic               host_rsp_ready,
  output logic [HOST_DW-1:0] host_rsp_data,
  input  logic               remap_q,
  input  logic [7:0]         page_q,
  output logic               wr_fire,
  output host_tgt_e          tgt,
  output logic               ram_we,
  output logic               ram_re,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [HOST_DW-1:0] ram_wdata,
  input  logic [HOST_DW-1:0] ram_rdata
);
  logic               fire;
  logic               page_ok;
  logic               win_ok;
  logic               rsp_live;
  logic [HOST_DW-1:0] rsp_hold;
  logic [HOST_DW-1:0] reg_rd;

  assign tgt            = decode_tgt(host_req_page);
  assign host_req_ready = ~host_rsp_valid;
  assign fire           = host_req_valid & host_req_ready;
  assign wr_fire        = fire & host_req_write;

  generate
    if (PAGE_W < 8) begin : g_page_range
      assign page_ok = (page_q[7:PAGE_W] == '0);
    end else begin : g_page_full
      assign page_ok = 1'b1;
    end
  endgenerate

  assign win_ok    = (tgt == TGT_WINDOW) & page_ok & ~remap_q;
  assign ram_we    = fire & host_req_write & win_ok;
  assign ram_re    = fire & ~host_req_write & win_ok;
  assign ram_addr  = {page_q[PAGE_W-1:0], host_req_offset[OFS_W-1:0]};
  assign ram_wdata = host_req_wdata;

  always_comb begin
    reg_rd = '0;
    case (tgt)
      TGT_REMAP: if (host_req_offset == 8'h00) reg_rd = {{(HOST_DW-1){1'b0}}, remap_q};
      TGT_PAGE:  reg_rd = page_q;
      default:   reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      rsp_live       <= 1'b0;
      rsp_hold       <= '0;
    end else begin
      if (rsp_live) begin
        rsp_hold <= ram_rdata;
        rsp_live <= 1'b0;
      end
      if (host_rsp_valid && host_rsp_ready) host_rsp_valid <= 1'b0;
      if (fire && !host_req_write) begin
        host_rsp_valid <= 1'b1;
        rsp_live       <= win_ok;
        if (!win_ok) rsp_hold <= reg_rd;
      end
    end
  end

  assign host_rsp_data = rsp_live ? ram_rdata : rsp_hold;

  // R7: the window stays shut while remap is set
  assert_win_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> !remap_q);
  // R5: strobes only for pages inside the RAM
  assert_page_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (page_q <= 8'(NUM_PAGES - 1)));
  // R4: a RAM read is answered on the next cycle
  assert_read_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> host_rsp_valid);
  // R11: a stalled response keeps its data
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=> (host_rsp_valid && $stable(host_rsp_data)));
endmodule

// File: rtl/devwin_cpu_decode.sv
module devwin_cpu_decode #(
  parameter int                CPU_AW   = 16,
  parameter int                RAM_AW   = 13,
  parameter logic [CPU_AW-1:0] OTP_BASE = '0,
  parameter logic [CPU_AW-1:0] SEP_BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remap_q,
  input  logic              trace_en,
  input  logic              cpu_valid,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              cpu_sel_otp,
  output logic              cpu_sel_ram,
  output logic [RAM_AW-1:0] cpu_ram_addr
);
  logic in_otp;
  logic in_sep;
  logic overlay;

  assign in_otp  = (cpu_addr[CPU_AW-1:RAM_AW] == OTP_BASE[CPU_AW-1:RAM_AW]);
  assign in_sep  = (cpu_addr[CPU_AW-1:RAM_AW] == SEP_BASE[CPU_AW-1:RAM_AW]);
  assign overlay = remap_q & ~trace_en;

  assign cpu_sel_otp  = cpu_valid & in_otp & ~overlay;
  assign cpu_sel_ram  = cpu_valid & ((in_otp & overlay) | (in_sep & ~overlay));
  assign cpu_ram_addr = cpu_addr[RAM_AW-1:0];

  // R8: OTP and RAM never selected together
  assert_sel_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel_otp && cpu_sel_ram));
  // R10: trace capture keeps the RAM off the OTP range
  assert_trace_no_overlay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && (cpu_addr[CPU_AW-1:RAM_AW] == OTP_BASE[CPU_AW-1:RAM_AW])) |-> !cpu_sel_ram);
endmodule

// File: rtl/devram_window.sv
module devram_window
  import devwin_pkg::*;
#(
  parameter int RAM_BYTES = 8192,
  parameter int WIN_BYTES = 256,
  parameter int CPU_AW    = 16,
  parameter logic [CPU_AW-1:0] OTP_BASE = '0,
  parameter logic [CPU_AW-1:0] SEP_BASE = 16'h4000,
  localparam int RAM_AW    = $clog2(RAM_BYTES),
  localparam int OFS_W     = $clog2(WIN_BYTES),
  localparam int PAGE_W    = RAM_AW - OFS_W,
  localparam int NUM_PAGES = RAM_BYTES / WIN_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic [7:0]         host_req_page,
  input  logic [7:0]         host_req_offset,
  input  logic [HOST_DW-1:0] host_req_wdata,
  output logic               host_rsp_valid,
  input  logic               host_rsp_ready,
  output logic [HOST_DW-1:0] host_rsp_data,
  output logic               ram_we,
  output logic               ram_re,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [HOST_DW-1:0] ram_wdata,
  input  logic [HOST_DW-1:0] ram_rdata,
  input  logic               trace_en,
  input  logic               cpu_valid,
  input  logic [CPU_AW-1:0]  cpu_addr,
  output logic               cpu_sel_otp,
  output logic               cpu_sel_ram,
  output logic [RAM_AW-1:0]  cpu_ram_addr
);
  logic      remap_q;
  logic [7:0] page_q;
  logic      wr_fire;
  host_tgt_e tgt;

  devwin_host_port #(
    .RAM_AW(RAM_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)
  ) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_page(host_req_page),
    .host_req_offset(host_req_offset), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_data(host_rsp_data),
    .remap_q(remap_q), .page_q(page_q), .wr_fire(wr_fire), .tgt(tgt),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  devwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .tgt(tgt),
    .offset(host_req_offset), .wdata(host_req_wdata),
    .remap_q(remap_q), .page_q(page_q)
  );

  devwin_cpu_decode #(
    .CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .OTP_BASE(OTP_BASE), .SEP_BASE(SEP_BASE)
  ) u_cpu (
    .clk(clk), .rst_n(rst_n), .remap_q(remap_q), .trace_en(trace_en),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_sel_otp(cpu_sel_otp), .cpu_sel_ram(cpu_sel_ram),
    .cpu_ram_addr(cpu_ram_addr)
  );
endmodule

// File: tb/test_devram_window.sv
module test_devram_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req_valid, host_req_ready, host_req_write;
  logic [7:0]  host_req_page, host_req_offset, host_req_wdata;
  logic        host_rsp_valid, host_rsp_ready;
  logic [7:0]  host_rsp_data;
  logic        ram_we, ram_re;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        trace_en, cpu_valid;
  logic [15:0] cpu_addr;
  logic        cpu_sel_otp, cpu_sel_ram;
  logic [12:0] cpu_ram_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench-side RAM macro and reference model
  logic [7:0] mac_mem [8192];
  logic [7:0] ref_mem [8192];
  logic       ref_remap;
  logic [7:0] ref_page;
  bit         ref_pend;
  logic [7:0] ref_rsp_data;
  string      ref_rsp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  devram_window i_devram_window (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_page(host_req_page),
    .host_req_offset(host_req_offset), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_data(host_rsp_data),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .trace_en(trace_en), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_sel_otp(cpu_sel_otp), .cpu_sel_ram(cpu_sel_ram),
    .cpu_ram_addr(cpu_ram_addr)
  );

  always @(posedge clk) begin
    if (ram_we) mac_mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mac_mem[ram_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_read(input logic [7:0] pg, input logic [7:0] off);
    case (pg)
      8'h00: return (off == 8'h00) ? {7'b0, ref_remap} : 8'h00;
      8'h02: return ref_page;
      8'h03: return (ref_page < 8'd32 && !ref_remap) ? ref_mem[{ref_page[4:0], off}] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] pg);
    case (pg)
      8'h00: return "R6";
      8'h02: return "R2";
      8'h03: return (ref_page >= 8'd32) ? "R5" : (ref_remap ? "R7" : "R4");
      default: return "R12";
    endcase
  endfunction

  // one clock: compare all outputs against the model, then advance the model
  task automatic step();
    bit exp_ready, fire, win, ovl, otp, sep, e_otp, e_ram;
    string wtag, ctag;
    #1;
    exp_ready = !ref_pend;
    fire = host_req_valid && exp_ready;
    win  = (host_req_page == 8'h03) && (ref_page < 8'd32) && !ref_remap;
    wtag = (host_req_page == 8'h03 && ref_page >= 8'd32) ? "R5" :
           (host_req_page == 8'h03 && ref_remap) ? "R7" :
           (host_req_page != 8'h03) ? "R12" : (host_req_write ? "R3" : "R4");
    chk("R11 ready", host_req_ready, exp_ready);
    chk({wtag, " we"}, ram_we, fire && host_req_write && win);
    chk({wtag, " re"}, ram_re, fire && !host_req_write && win);
    if (fire && win) begin
      chk("R3 addr", ram_addr, {ref_page[4:0], host_req_offset});
      if (host_req_write) chk("R3 wdata", ram_wdata, host_req_wdata);
    end
    chk("R11 rsp_valid", host_rsp_valid, ref_pend);
    if (ref_pend) chk({ref_rsp_tag, " rsp_data"}, host_rsp_data, ref_rsp_data);
    ovl = ref_remap && !trace_en;
    otp = cpu_addr[15:13] == 3'd0;
    sep = cpu_addr[15:13] == 3'd2;
    e_otp = cpu_valid && otp && !ovl;
    e_ram = cpu_valid && ((otp && ovl) || (sep && !ovl));
    ctag = trace_en ? "R10" : (otp ? "R8" : "R9");
    chk({ctag, " sel_otp"}, cpu_sel_otp, e_otp);
    chk({ctag, " sel_ram"}, cpu_sel_ram, e_ram);
    if (e_ram) chk("R9 cpu_ram_addr", cpu_ram_addr, cpu_addr[12:0]);
    @(posedge clk);
    if (ref_pend && host_rsp_ready) ref_pend = 0;
    if (fire) begin
      if (host_req_write) begin
        if (host_req_page == 8'h00 && host_req_offset == 8'h00) ref_remap = host_req_wdata[0];
        else if (host_req_page == 8'h02) ref_page = host_req_wdata;
        else if (win) ref_mem[{ref_page[4:0], host_req_offset}] = host_req_wdata;
      end else begin
        ref_pend = 1;
        ref_rsp_data = ref_read(host_req_page, host_req_offset);
        ref_rsp_tag = read_tag(host_req_page);
      end
    end
    @(negedge clk);
  endtask

  task automatic hwr(input logic [7:0] pg, input logic [7:0] off, input logic [7:0] d);
    host_req_valid = 1; host_req_write = 1;
    host_req_page = pg; host_req_offset = off; host_req_wdata = d;
    step();
    host_req_valid = 0;
  endtask

  task automatic hrd(input logic [7:0] pg, input logic [7:0] off);
    host_req_valid = 1; host_req_write = 0;
    host_req_page = pg; host_req_offset = off;
    step();
    host_req_valid = 0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mac_mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    ref_remap = 0; ref_page = 0; ref_pend = 0; ref_rsp_data = 0; ref_rsp_tag = "R4";
    rst_n = 0; host_req_valid = 0; host_req_write = 0; host_req_page = 0;
    host_req_offset = 0; host_req_wdata = 0; host_rsp_ready = 1;
    trace_en = 0; cpu_valid = 0; cpu_addr = 0; ram_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", host_req_ready, 1);
    chk("R1 rsp_valid", host_rsp_valid, 0);
    chk("R1 we", ram_we, 0);
    chk("R1 re", ram_re, 0);
    host_req_valid = 1; host_req_page = 8'h02; step(); host_req_valid = 0;
    #1 chk("R1 page reset", host_rsp_data, 0);
    step();
    host_req_valid = 1; host_req_page = 8'h00; host_req_offset = 0; step(); host_req_valid = 0;
    #1 chk("R1 remap reset", host_rsp_data, 0);
    step();

    // R2 / R3 / R4: paged download and readback
    for (int p = 0; p < 32; p += 7) begin
      hwr(8'h02, 8'(p), 8'(p));
      hrd(8'h02, 8'h11);
      hwr(8'h03, 8'h00, 8'(p + 8'h30));
      hwr(8'h03, 8'hFF, 8'(p + 8'hC0));
      hwr(8'h03, 8'h80, 8'(p ^ 8'hA5));
      hrd(8'h03, 8'h00);
      hrd(8'h03, 8'hFF);
      hrd(8'h03, 8'h80);
      hrd(8'h03, 8'h41);
    end
    hwr(8'h02, 8'd31, 8'h00);
    hwr(8'h03, 8'hFF, 8'hE7);
    hrd(8'h03, 8'hFF);

    // R5: out-of-range pages
    hwr(8'h02, 8'd32, 8'h00);
    hwr(8'h03, 8'h10, 8'h99);
    hrd(8'h03, 8'h10);
    hwr(8'h02, 8'd200, 8'h00);
    hrd(8'h03, 8'h00);
    hwr(8'h02, 8'd0, 8'h00);
    hrd(8'h03, 8'h10);

    // R6 / R7: remap register and blocked window
    hwr(8'h00, 8'h00, 8'hFF);
    hrd(8'h00, 8'h00);
    hrd(8'h00, 8'h01);
    hwr(8'h03, 8'h05, 8'h77);
    hrd(8'h03, 8'h05);
    hwr(8'h00, 8'h01, 8'h00);
    hrd(8'h00, 8'h00);
    cpu_valid = 1;
    for (int a = 0; a < 8; a++) begin
      cpu_addr = 16'(a * 16'h2000 + a * 37);
      trace_en = 0; step();
      trace_en = 1; step();
    end
    hwr(8'h00, 8'h00, 8'h00);
    hrd(8'h03, 8'h05);
    for (int a = 0; a < 8; a++) begin
      cpu_addr = 16'(a * 16'h2000 + 16'h1FFF);
      trace_en = 0; step();
      cpu_valid = 0; step(); cpu_valid = 1;
    end

    // R12: unmapped pages
    hwr(8'h01, 8'h00, 8'h01);
    hwr(8'h07, 8'h02, 8'h1F);
    hrd(8'h01, 8'h00);
    hrd(8'hFF, 8'h00);
    hrd(8'h00, 8'h00);
    hrd(8'h02, 8'h00);

    // R11: back-pressure over several cycles
    host_rsp_ready = 0;
    host_req_valid = 1; host_req_write = 0; host_req_page = 8'h03; host_req_offset = 8'h00;
    step();
    host_req_offset = 8'hFF;
    repeat (4) step();
    host_rsp_ready = 1;
    step();
    step();
    host_req_valid = 0;
    step();

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      host_req_valid  = ($urandom_range(0, 3) != 0);
      host_req_write  = $urandom_range(0, 1) == 1;
      sel = $urandom_range(0, 9);
      host_req_page   = (sel < 5) ? 8'h03 : (sel < 7) ? 8'h02 : (sel < 8) ? 8'h00 : 8'(sel);
      host_req_offset = (host_req_page == 8'h00) ? 8'($urandom_range(0, 1)) : 8'($urandom);
      host_req_wdata  = (host_req_page == 8'h02) ? 8'($urandom_range(0, 36)) :
                        (host_req_page == 8'h00) ? 8'($urandom_range(0, 7) == 0) : 8'($urandom);
      host_rsp_ready  = ($urandom_range(0, 3) != 0);
      trace_en        = ($urandom_range(0, 3) == 0);
      cpu_valid       = $urandom_range(0, 1) == 1;
      cpu_addr        = 16'($urandom);
      step();
    end
    host_req_valid = 0; host_rsp_ready = 1;
    step(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule